// File: doc/BRIEF.md
# QPSK Soft-Decision Branch Metric Unit

This block turns one received QPSK symbol, given as a pair of signed soft values for the in-phase and quadrature rails, into the four branch metrics a rate-1/2 Viterbi decoder needs. There is one metric for each hypothesis on the two coded bits. Each metric is an offset constant plus or minus each soft value, so a larger metric means a closer match. This suits an add-compare-select stage that keeps the larger sum.

The four metrics leave the block packed into byte lanes of one word. The add-compare-select stage can then take all hypotheses for a symbol in a single transfer. Samples enter through a valid/ready handshake. The packed word leaves through a second valid/ready pair after one register stage. When the output is stalled, the input is stalled too.

Top module: `qpsk_branch_metric`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Byte lane 0 (`out_metrics[7:0]`) holds the metric for coded pair 00, which is 127 + I + Q.
- R3: Byte lane 1 (`out_metrics[15:8]`) holds the metric for coded pair 01, which is 127 + I - Q.
- R4: Byte lane 2 (`out_metrics[23:16]`) holds the metric for coded pair 10, which is 127 - I + Q.
- R5: Byte lane 3 (`out_metrics[31:24]`) holds the metric for coded pair 11, which is 127 - I - Q.
- R6: I and Q are 6-bit two's-complement values (-32 to +31), sign-extended before the arithmetic. Each lane is clamped to 0..255, so at this width no clamping occurs and lanes 0+3 and lanes 1+2 each sum to 254.
- R7: A sample accepted on a clock edge (`in_valid` and `in_ready` both high) is presented with `out_valid` high right after that edge.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_metrics` holds its value.
- R9: When the output word is taken and no new sample is accepted on the same edge, `out_valid` is low after that edge.
- R10: The extreme inputs give the extreme lanes. With I = Q = -32, lane 0 is 63 and lane 3 is 191. With I = Q = 31, lane 0 is 189 and lane 3 is 65.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Soft sample pair present |
| in_ready | output | 1 | Block can accept a sample |
| in_i | input | 6 | In-phase soft value, two's complement |
| in_q | input | 6 | Quadrature soft value, two's complement |
| out_valid | output | 1 | Packed metric word present |
| out_ready | input | 1 | Downstream takes the word |
| out_metrics | output | 32 | Four 8-bit metrics, coded pair 00 in the low byte |

## Verification
The lane-sum property assumes that the offset and the soft width are such that no lane can clamp. At the default width, every 6-bit input pattern meets this, so the stimulus cannot leave that range. The handshake properties assume that the downstream side does not change `out_ready` between edges. The bench drives all inputs on the falling edge. Random `out_ready` and `in_valid` patterns cover the stall and bubble cases, and directed samples reach the most negative and most positive soft values.

// File: rtl/qpsk_branch_metric.sv
module qpsk_branch_metric #(
  parameter int SOFT_W = 6,
  parameter int MW     = 8,
  parameter int OFFSET = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SOFT_W-1:0] in_i,
  input  logic [SOFT_W-1:0] in_q,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [4*MW-1:0]   out_metrics
);
  localparam int BASE_W = (MW > SOFT_W + 1) ? MW : SOFT_W + 1;
  localparam int SUM_W  = BASE_W + 2;
  localparam logic signed [SUM_W-1:0] OFF  = SUM_W'(OFFSET);
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << MW) - 1);

  logic signed [SUM_W-1:0] ie, qe;
  logic [4*MW-1:0] lanes;
  logic take;

  assign ie = {{(SUM_W-SOFT_W){in_i[SOFT_W-1]}}, in_i};
  assign qe = {{(SUM_W-SOFT_W){in_q[SOFT_W-1]}}, in_q};

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic signed [SUM_W-1:0] a, s;
    if (k[1]) begin : g_neg_i
      assign a = OFF - ie;
    end else begin : g_pos_i
      assign a = OFF + ie;
    end
    if (k[0]) begin : g_neg_q
      assign s = a - qe;
    end else begin : g_pos_q
      assign s = a + qe;
    end
    assign lanes[k*MW +: MW] = (s < 0)    ? '0 :
                               (s > MAXV) ? '1 : s[MW-1:0];
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_metrics <= '0;
    end else begin
      if (take) out_metrics <= lanes;
      if (in_ready) out_valid <= in_valid;
    end
  end
endmodule

// File: rtl/qpsk_branch_metric_chk.sv
module qpsk_branch_metric_chk #(
  parameter int SOFT_W = 6,
  parameter int MW     = 8,
  parameter int OFFSET = 127
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [4*MW-1:0] out_metrics
);
  localparam bit NO_SAT = (OFFSET >= (1 << (SOFT_W-1)) * 2) &&
                          (OFFSET + (1 << (SOFT_W-1)) * 2 <= (1 << MW) - 1);

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_accept_shows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_metrics));

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  if (NO_SAT) begin : g_sum
    p_lane_pairs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |->
        ({1'b0, out_metrics[MW-1:0]} + {1'b0, out_metrics[4*MW-1:3*MW]} == (MW+1)'(2*OFFSET)) &&
        ({1'b0, out_metrics[2*MW-1:MW]} + {1'b0, out_metrics[3*MW-1:2*MW]} == (MW+1)'(2*OFFSET)));
  end
endmodule

bind qpsk_branch_metric qpsk_branch_metric_chk #(.SOFT_W(SOFT_W), .MW(MW), .OFFSET(OFFSET)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_metrics(out_metrics)
);

// File: tb/test_qpsk_branch_metric.sv
module test_qpsk_branch_metric;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [5:0] in_i = 0, in_q = 0;
  logic in_ready, out_valid;
  logic [31:0] out_metrics;
  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  bit done = 0;

  always #10 clk = ~clk;

  qpsk_branch_metric i_qpsk_branch_metric (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_ready(out_ready),
    .out_metrics(out_metrics)
  );

  function automatic logic [7:0] bm(int i, int q, bit c0, bit c1);
    int s = 127 + (c0 ? -i : i) + (c1 ? -q : q);
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return 8'(s);
  endfunction

  function automatic logic [31:0] pack(logic [5:0] i6, logic [5:0] q6);
    int i = $signed(i6), q = $signed(q6);
    return {bm(i, q, 1, 1), bm(i, q, 1, 0), bm(i, q, 0, 1), bm(i, q, 0, 0)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  bit prev_take = 0, prev_drain = 0;

  task automatic step(bit iv, bit ordy, logic [5:0] i, logic [5:0] q);
    logic [31:0] e;
    in_valid = iv; out_ready = ordy; in_i = i; in_q = q;
    #1;
    if (prev_take) check("R7", 32'(out_valid), 32'd1);
    if (prev_drain) check("R9", 32'(out_valid), 32'd0);
    if (out_valid && !out_ready) check("R8", 32'(in_ready), 32'd0);
    if (out_valid) begin
      e = (exp_q.size() > 0) ? exp_q[0] : 32'hx;
      check("R2", 32'(out_metrics[7:0]), 32'(e[7:0]));
      check("R3", 32'(out_metrics[15:8]), 32'(e[15:8]));
      check("R4", 32'(out_metrics[23:16]), 32'(e[23:16]));
      check("R5", 32'(out_metrics[31:24]), 32'(e[31:24]));
      check("R6", 32'(out_metrics[7:0]) + 32'(out_metrics[31:24]), 32'd254);
      if (out_ready && exp_q.size() > 0) void'(exp_q.pop_front());
    end
    prev_drain = out_valid && out_ready && !(in_valid && in_ready);
    prev_take  = in_valid && in_ready;
    if (prev_take) exp_q.push_back(pack(i, q));
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R1", 32'(out_valid), 32'd0);
    check("R1", 32'(in_ready), 32'd1);
    rst_n = 1;
    @(negedge clk);
    // R10 extremes
    step(1, 1, 6'h20, 6'h20);
    check("R10", 32'(out_metrics[7:0]), 32'd63);
    check("R10", 32'(out_metrics[31:24]), 32'd191);
    step(1, 1, 6'h1F, 6'h1F);
    check("R10", 32'(out_metrics[7:0]), 32'd189);
    check("R10", 32'(out_metrics[31:24]), 32'd65);
    step(1, 1, 6'h20, 6'h1F);
    step(1, 1, 6'h00, 6'h00);
    step(0, 0, 6'h05, 6'h3A);
    step(0, 0, 6'h05, 6'h3A);
    step(0, 1, 6'h00, 6'h00);
    for (int n = 0; n < 3000; n++)
      step(bit'($urandom % 4 != 0), bit'($urandom % 3 != 0),
           6'($urandom), 6'($urandom));
    step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule